// File: doc/BRIEF.md
# Line-Refill Backing Memory

This block is the data memory that sits behind a write-back data cache. It holds a window of bytes and moves data only in whole cache lines. A line is four 32-bit words, or sixteen bytes. When the cache misses, it raises a fetch request with an address. One clock later the memory returns the sixteen bytes of the line that holds that address and pulses a ready flag for one cycle. When the cache evicts a dirty line, it presents the line with its address and a valid strobe, and the memory stores all sixteen bytes in that clock.

Every request address loses its four low bits before use, so every transfer starts on a line boundary. Address bits at and above the window width are dropped, so the address space wraps over the window. The window is `2**WIN_AW` bytes. `WIN_AW = 17` gives the 128 KiB span from 0x00000 to 0x1FFFF. The default is smaller so that elaboration stays light.

Bytes are stored little-endian. Byte k of a line sits on bus bits [8k+7:8k] in both directions. Word i therefore occupies bits [(i+1)*32-1:i*32]. Its least significant byte comes from the lowest address of the word and its most significant byte from that address plus three.

A two-state controller (states `ST_IDLE` and `ST_SERVE`) produces the ready pulse. Its transitions are:

- **ST_IDLE to ST_SERVE:** taken when `fetch_en` is high.
- **ST_SERVE to ST_SERVE:** taken when `fetch_en` is high again (a back-to-back request).
- **ST_SERVE to ST_IDLE:** taken when `fetch_en` is low.
- **ST_IDLE to ST_IDLE:** taken when there is no request.

Top module: `line_refill_mem`

## Requirements
- R1: During and after reset, `line_ready` is 0 and `line_out` is all zeros until the first refill.
- R2: A cycle with `fetch_en` high is followed by exactly one cycle with `line_ready` high. `line_ready` is never high in a cycle that does not follow a `fetch_en` cycle.
- R3: In a returned line, bits [8k+7:8k] hold the byte at line base address plus k, for k = 0 to 15. Word i (bits [(i+1)*32-1:i*32]) therefore reads {byte 4i+3, byte 4i+2, byte 4i+1, byte 4i}.
- R4: The low four bits of `fetch_addr` have no effect. A refill returns the line at `fetch_addr & 0xFFFFFFF0`.
- R5: A cycle with `wb_valid` high stores bits [8k+7:8k] of `wb_line` at byte `(wb_addr & 0xFFFFFFF0) + k`, for all sixteen k. The low four bits of `wb_addr` have no effect.
- R6: When a write-back and a refill to the same line occur in one cycle, the refill returns the newly written line. When they target different lines, the refill returns the stored contents of its own line.
- R7: Address bits at positions WIN_AW and above are ignored on both paths. Two addresses that differ only there name the same line.
- R8: `line_out` changes only in the cycle after a `fetch_en` cycle. A write-back on its own changes neither `line_out` nor `line_ready`.
- R9: Refill requests on consecutive cycles each return their own line, one cycle after their request, with `line_ready` high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_en | input | 1 | Refill request strobe |
| fetch_addr | input | ADDR_W (32) | Refill byte address |
| wb_valid | input | 1 | Write-back strobe |
| wb_addr | input | ADDR_W (32) | Write-back byte address |
| wb_line | input | LINE_W (128) | Line to store, byte k on bits [8k+7:8k] |
| line_out | output | LINE_W (128) | Returned line, byte k on bits [8k+7:8k] |
| line_ready | output | 1 | One-cycle pulse marking a fresh `line_out` |

## Verification
The assertions check the timing of the handshake on every cycle:

- `line_ready` follows each request and has no other cause.
- `line_out` holds steady unless a request preceded it.
- Each byte lane forwards a same-cycle write into the read it is serving.

Only the bench scenarios can show that the stored data is right. It sweeps every line of the window and checks the byte and word order. It also checks alignment masking, wrap-around of the high address bits, write-versus-read ordering across same and different lines, and back-to-back refills.

// File: rtl/lmem_pkg.sv
package lmem_pkg;

    // Controller states for the refill response
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } lmem_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/lmem_align.sv
module lmem_align #(
    parameter int ADDR_W = 32,
    parameter int WIN_AW = 12,
    parameter int OFFS_W = 4,
    localparam int IDX_W = WIN_AW - OFFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  line_idx
);

    logic [ADDR_W-1:0] aligned;
    logic              unused_bits;

    // Clear the in-line offset, then keep only the in-window line number
    always_comb begin
        aligned     = addr & ~ADDR_W'((1 << OFFS_W) - 1);
        line_idx    = aligned[WIN_AW-1:OFFS_W];
        unused_bits = ^{aligned[ADDR_W-1:WIN_AW], aligned[OFFS_W-1:0]};
    end

endmodule

// File: rtl/lmem_lane.sv
module lmem_lane #(
    parameter int IDX_W = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic             re,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       q
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read port: a same-cycle write to the same slot is seen by the read
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (re) begin
            if (we && (waddr == raddr)) begin
                q <= wdata;
            end else begin
                q <= mem[raddr];
            end
        end
    end

    a_r6_write_before_read: assert property (@(posedge clk) disable iff (rst)
        (re && we && (waddr == raddr)) |=> (q == $past(wdata)))
        else $error("R6: lane read missed same-cycle write");

endmodule

// File: rtl/lmem_ctrl.sv
module lmem_ctrl
    import lmem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fetch_en,
    output logic ready
);

    lmem_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = fetch_en ? ST_SERVE : ST_IDLE;
            ST_SERVE: state_nx = fetch_en ? ST_SERVE : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        ready = 1'b0;
        unique case (state)
            ST_IDLE:  ready = 1'b0;
            ST_SERVE: ready = 1'b1;
            default:  ready = 1'b0;
        endcase
    end

    a_r2_ready_follows_fetch: assert property (@(posedge clk) disable iff (rst)
        fetch_en |=> ready)
        else $error("R2: request not answered");

    a_r2_ready_has_cause: assert property (@(posedge clk) disable iff (rst)
        ready |-> $past(fetch_en))
        else $error("R2: ready without request");

endmodule

// File: rtl/line_refill_mem.sv
module line_refill_mem #(
    parameter int ADDR_W     = 32,
    parameter int WIN_AW     = 12,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    localparam int LINE_W     = WORD_W * LINE_WORDS,
    localparam int LINE_BYTES = LINE_W / lmem_pkg::BYTE_W,
    localparam int OFFS_W     = $clog2(LINE_BYTES),
    localparam int IDX_W      = WIN_AW - OFFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_en,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              wb_valid,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [LINE_W-1:0] wb_line,
    output logic [LINE_W-1:0] line_out,
    output logic              line_ready
);

    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;

    lmem_align #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .OFFS_W(OFFS_W)) u_rd_align (
        .addr     (fetch_addr),
        .line_idx (rd_idx)
    );

    lmem_align #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .OFFS_W(OFFS_W)) u_wr_align (
        .addr     (wb_addr),
        .line_idx (wr_idx)
    );

    // One storage lane per byte position of the line (little-endian lanes)
    for (genvar k = 0; k < LINE_BYTES; k++) begin : g_lane
        lmem_lane #(.IDX_W(IDX_W)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .we    (wb_valid),
            .waddr (wr_idx),
            .wdata (wb_line[8*k +: 8]),
            .re    (fetch_en),
            .raddr (rd_idx),
            .q     (line_out[8*k +: 8])
        );
    end

    lmem_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .fetch_en (fetch_en),
        .ready    (line_ready)
    );

    a_r8_line_holds: assert property (@(posedge clk) disable iff (rst)
        !fetch_en |=> $stable(line_out))
        else $error("R8: line changed without request");

    a_r8_wb_no_ready: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !fetch_en) |=> !line_ready)
        else $error("R8: write-back raised ready");

endmodule

// File: tb/test_line_refill_mem.sv
`timescale 1ns/1ps
module test_line_refill_mem;

    localparam int WIN_AW = 12;
    localparam int NLINES = 1 << (WIN_AW - 4);

    logic         clk = 1'b0;
    logic         rst;
    logic         fetch_en;
    logic [31:0]  fetch_addr;
    logic         wb_valid;
    logic [31:0]  wb_addr;
    logic [127:0] wb_line;
    logic [127:0] line_out;
    logic         line_ready;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    line_refill_mem #(.WIN_AW(WIN_AW)) i_line_refill_mem (
        .clk        (clk),
        .rst        (rst),
        .fetch_en   (fetch_en),
        .fetch_addr (fetch_addr),
        .wb_valid   (wb_valid),
        .wb_addr    (wb_addr),
        .wb_line    (wb_line),
        .line_out   (line_out),
        .line_ready (line_ready)
    );

    function automatic logic [127:0] pat(int ln, int seed);
        logic [127:0] r;
        for (int k = 0; k < 16; k++) begin
            r[8*k +: 8] = 8'(ln * 37 + k * 11 + seed * 101 + 3);
        end
        return r;
    endfunction

    task automatic check(logic [127:0] act, logic [127:0] exp, string req);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wb(logic [31:0] a, logic [127:0] d);
        @(negedge clk);
        wb_valid = 1'b1; wb_addr = a; wb_line = d;
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic fetch(logic [31:0] a);
        @(negedge clk);
        fetch_en = 1'b1; fetch_addr = a;
        @(negedge clk);
        fetch_en = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_cmp++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; fetch_en = 1'b0; fetch_addr = '0;
        wb_valid = 1'b0; wb_addr = '0; wb_line = '0;
        repeat (3) @(negedge clk);
        check(128'(line_ready), 128'd0, "R1 ready in reset");
        rst = 1'b0;
        @(negedge clk);
        check(128'(line_ready), 128'd0, "R1 ready after reset");
        check(line_out, 128'd0, "R1 line after reset");

        // R5 R7: fill every line, with offset garbage and high bits on odd lines
        for (int ln = 0; ln < NLINES; ln++) begin
            logic [31:0] a;
            a = 32'(ln << 4) | 32'(ln & 15);
            if (ln[0]) a = a | 32'h5A00_0000 | 32'(1 << WIN_AW);
            wb(a, pat(ln, 0));
        end
        check(128'(line_ready), 128'd0, "R8 no ready from write-back");
        check(line_out, 128'd0, "R8 line unchanged by write-back");

        // R3 R4 R7: sweep every line with varied offsets and aliasing high bits
        for (int ln = 0; ln < NLINES; ln++) begin
            logic [31:0] a;
            a = 32'(ln << 4) | 32'((ln * 5) & 15);
            if (!ln[0]) a = a | 32'hC300_0000 | 32'(3 << WIN_AW);
            fetch(a);
            check(128'(line_ready), 128'd1, "R2 ready one cycle after fetch");
            check(line_out, pat(ln, 0), "R3 R4 R5 R7 line contents");
            @(negedge clk);
            check(128'(line_ready), 128'd0, "R2 single ready pulse");
        end

        // R3: explicit word assembly of line 2, word 1
        fetch(32'h0000_0020);
        begin
            logic [7:0] b [16];
            for (int k = 0; k < 16; k++) b[k] = 8'(2 * 37 + k * 11 + 3);
            check(128'(line_out[63:32]), 128'({b[7], b[6], b[5], b[4]}), "R3 word 1 little-endian");
            check(128'(line_out[127:96]), 128'({b[15], b[14], b[13], b[12]}), "R3 word 3 little-endian");
        end

        // R8: write-back to the line just read leaves output alone
        wb(32'h0000_0020, pat(2, 9));
        check(line_out, pat(2, 0), "R8 output held over write-back");
        check(128'(line_ready), 128'd0, "R8 ready low over write-back");

        // R6: same-cycle write-back and refill, same line
        @(negedge clk);
        wb_valid = 1'b1; wb_addr = 32'h0000_0057; wb_line = pat(5, 1);
        fetch_en = 1'b1; fetch_addr = 32'h0000_005C;
        @(negedge clk);
        wb_valid = 1'b0; fetch_en = 1'b0;
        check(line_out, pat(5, 1), "R6 same line sees new write");
        check(128'(line_ready), 128'd1, "R6 ready");

        // R6: different lines in one cycle
        @(negedge clk);
        wb_valid = 1'b1; wb_addr = 32'h0000_0060; wb_line = pat(6, 2);
        fetch_en = 1'b1; fetch_addr = 32'h0000_0070;
        @(negedge clk);
        wb_valid = 1'b0; fetch_en = 1'b0;
        check(line_out, pat(7, 0), "R6 other line unaffected");
        fetch(32'h0000_0064);
        check(line_out, pat(6, 2), "R6 write landed");

        // R9: back-to-back refills
        @(negedge clk);
        fetch_en = 1'b1; fetch_addr = 32'h0000_0010;
        @(negedge clk);
        fetch_addr = 32'h0000_0033;
        check(line_out, pat(1, 0), "R9 first line");
        check(128'(line_ready), 128'd1, "R9 ready first");
        @(negedge clk);
        fetch_addr = 32'h0000_004F;
        check(line_out, pat(3, 0), "R9 second line");
        check(128'(line_ready), 128'd1, "R9 ready second");
        @(negedge clk);
        fetch_en = 1'b0;
        check(line_out, pat(4, 0), "R9 third line");
        check(128'(line_ready), 128'd1, "R9 ready third");
        @(negedge clk);
        check(128'(line_ready), 128'd0, "R2 ready drops after burst");
        check(line_out, pat(4, 0), "R8 line held when idle");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule